// File: doc/BRIEF.md
# Timer Interrupt Enable and Status Register

This block gathers the expiry pulses of a group of timer channels (five by default) into one bus-visible word. Each channel owns an enable bit and a sticky status flag. An expiry pulse always latches the channel's flag. The channel's interrupt line is high while both the flag and the enable are set.

Software reads the whole word through one read port. A single write updates the enable field and acknowledges flags at the same time. In the enable field, each written bit becomes the new enable value. In the status field, a written one clears the matching flag and a written zero leaves it as it is. The interrupt lines are registered. They follow the flag and enable state from the same clock edge that updates that state.

Top module: `tmr_irq_ctl`

## Requirements
- R1: The word has a fixed layout. Bits [4:0] hold the enables, with channel x at bit x. Bits [9:5] hold the status flags, with channel x at bit 5+x.
- R2: A one on `expire_i[x]` at a clock edge sets status flag x. This happens whatever the value of enable x, and the flag reads back as set after that edge.
- R3: A write (`wr_en_i` high) loads the enable field from `wr_data_i[4:0]` at that edge.
- R4: In a write, a one at `wr_data_i[5+x]` clears flag x. A zero at that position leaves flag x unchanged.
- R5: `irq_o[x]` is high exactly when flag x and enable x are both set. It changes on the same edge as the register. Setting an enable while its flag is already set raises the line, and clearing the flag lowers it.
- R6: After a synchronous reset, the read word and every interrupt line are zero.
- R7: If an expiry and a clearing write reach the same flag in one cycle, the flag stays set.
- R8: Read bits [31:10] are always zero.
- R9: With `wr_en_i` low, the enable field keeps its value. `wr_data_i` then has no effect on either field.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| expire_i | input | 5 | One-cycle expiry pulse per channel |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 32 | Write data |
| rd_data_o | output | 32 | Current register word |
| irq_o | output | 5 | Registered level interrupt per channel |

## Verification
A wrong enable or flag bit shows on `rd_data_o` at the first sample after the edge that should have set it. The same error shows on `irq_o` whenever the matching other bit is set. A lost expiry, a clear that misses, or a clear that wins against an expiry therefore appears one clock later on both outputs. An interrupt line that is stale by one cycle shows up the moment an enable or a flag toggles while the other bit is already set. The sweep over every pair of enable and flag patterns exposes both kinds of fault at once.

// File: rtl/tmr_irq_pkg.sv
package tmr_irq_pkg;
  localparam int DEF_CH = 5;
  localparam int DEF_DW = 32;

  function automatic int flag_pos(input int ch, input int num_ch);
    return num_ch + ch;
  endfunction
endpackage

// File: rtl/tmr_irq_enable_bank.sv
module tmr_irq_enable_bank #(
  parameter int NUM_CH = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en_i,
  input  logic [NUM_CH-1:0] wr_bits_i,
  output logic [NUM_CH-1:0] en_q_o,
  output logic [NUM_CH-1:0] en_next_o
);
  logic [NUM_CH-1:0] en_q;

  always_comb en_next_o = wr_en_i ? wr_bits_i : en_q;

  always_ff @(posedge clk) begin
    if (rst) en_q <= '0;
    else     en_q <= en_next_o;
  end

  assign en_q_o = en_q;

  assert_enable_load_R3: assert property (@(posedge clk) disable iff (rst)
    wr_en_i |=> en_q == $past(wr_bits_i));
  assert_enable_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !wr_en_i |=> $stable(en_q));
endmodule

// File: rtl/tmr_irq_flag_cell.sv
module tmr_irq_flag_cell (
  input  logic clk,
  input  logic rst,
  input  logic expire_i,
  input  logic clr_i,
  input  logic en_q_i,
  input  logic en_next_i,
  output logic flag_o,
  output logic irq_o
);
  logic flag_q, flag_next, irq_q;

  // An expiry takes priority over a clear.
  always_comb flag_next = expire_i | (flag_q & ~clr_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      flag_q <= flag_next;
      irq_q  <= flag_next & en_next_i;
    end
  end

  assign flag_o = flag_q;
  assign irq_o  = irq_q;

  assert_expiry_sets_R2: assert property (@(posedge clk) disable iff (rst)
    expire_i |=> flag_q);
  assert_clear_R4: assert property (@(posedge clk) disable iff (rst)
    (clr_i && !expire_i) |=> !flag_q);
  assert_keep_R4: assert property (@(posedge clk) disable iff (rst)
    (flag_q && !clr_i) |=> flag_q);
  assert_collision_R7: assert property (@(posedge clk) disable iff (rst)
    (clr_i && expire_i) |=> flag_q);
  assert_irq_level_R5: assert property (@(posedge clk) disable iff (rst)
    irq_q == (flag_q & en_q_i));
endmodule

// File: rtl/tmr_irq_ctl.sv
module tmr_irq_ctl #(
  parameter int NUM_CH = tmr_irq_pkg::DEF_CH,
  parameter int DATA_W = tmr_irq_pkg::DEF_DW
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] expire_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic [NUM_CH-1:0] irq_o
);
  localparam int USED_W = 2 * NUM_CH;

  logic [NUM_CH-1:0] en_q, en_next, flags;

  tmr_irq_enable_bank #(.NUM_CH(NUM_CH)) u_enables (
    .clk       (clk),
    .rst       (rst),
    .wr_en_i   (wr_en_i),
    .wr_bits_i (wr_data_i[NUM_CH-1:0]),
    .en_q_o    (en_q),
    .en_next_o (en_next)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    tmr_irq_flag_cell u_cell (
      .clk       (clk),
      .rst       (rst),
      .expire_i  (expire_i[c]),
      .clr_i     (wr_en_i & wr_data_i[tmr_irq_pkg::flag_pos(c, NUM_CH)]),
      .en_q_i    (en_q[c]),
      .en_next_i (en_next[c]),
      .flag_o    (flags[c]),
      .irq_o     (irq_o[c])
    );
  end

  always_comb begin
    rd_data_o                    = '0;
    rd_data_o[NUM_CH-1:0]        = en_q;
    rd_data_o[USED_W-1:NUM_CH]   = flags;
  end

  assert_upper_zero_R8: assert property (@(posedge clk) disable iff (rst)
    rd_data_o[DATA_W-1:USED_W] == '0);
  assert_irq_needs_enable_R5: assert property (@(posedge clk) disable iff (rst)
    (irq_o & ~rd_data_o[NUM_CH-1:0]) == '0);
endmodule

// File: tb/tmr_irq_ctl_tb_top.sv
module tmr_irq_ctl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 5;
  localparam int DW  = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NCH-1:0] expire = '0;
  logic wr_en = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] rd_data;
  logic [NCH-1:0] irq;

  int n_vec = 0;
  int n_bad = 0;
  logic [NCH-1:0] en_m = '0, st_m = '0;
  logic [31:0] lfsr = 32'h1ACE_B00C;

  always #(CLK_PERIOD/2) clk = ~clk;

  tmr_irq_ctl #(.NUM_CH(NCH), .DATA_W(DW)) dut_i (
    .clk(clk), .rst(rst), .expire_i(expire), .wr_en_i(wr_en),
    .wr_data_i(wr_data), .rd_data_o(rd_data), .irq_o(irq));

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%h expected=%h at %0t", req, got, exp, $time);
    end
  endtask

  // Drive one cycle's inputs, update the model at the edge, compare after it.
  task automatic step(input logic [NCH-1:0] ex, input logic w, input logic [31:0] d);
    expire = ex; wr_en = w; wr_data = d;
    @(posedge clk);
    st_m = (st_m & ~(w ? d[2*NCH-1:NCH] : '0)) | ex;
    if (w) en_m = d[NCH-1:0];
    @(negedge clk);
    expire = '0; wr_en = 1'b0; wr_data = '0;
    check("R3/R9 enable field", {27'd0, rd_data[NCH-1:0]}, {27'd0, en_m});
    check("R2/R4/R7 status field", {27'd0, rd_data[2*NCH-1:NCH]}, {27'd0, st_m});
    check("R8 upper bits", {10'd0, rd_data[31:10]}, 32'd0);
    check("R5 irq lines", {27'd0, irq}, {27'd0, st_m & en_m});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R6: reset state
    check("R6 reset word", rd_data, 32'd0);
    check("R6 reset irq", {27'd0, irq}, 32'd0);

    // R2: expiry latches even with every enable off
    step(5'b10101, 1'b0, '0);
    check("R2 flags with enables off", {22'd0, rd_data[9:0]}, 32'h2A0);
    // R9: data ignored without strobe
    step('0, 1'b0, 32'hFFFF_FFFF);
    check("R9 no strobe", {22'd0, rd_data[9:0]}, 32'h2A0);
    // R5: enabling a pending flag raises the line
    step('0, 1'b1, 32'h0000_0001);
    check("R5 enable pending", {27'd0, irq}, 32'h1);
    // R4: write-one clears only marked flags
    step('0, 1'b1, 32'h0000_0021);
    check("R4 partial clear", {22'd0, rd_data[9:0]}, 32'h281);
    check("R5 line drops on clear", {27'd0, irq}, 32'h0);
    // R7: expiry and clear on the same flag
    step(5'b00100, 1'b1, 32'h0000_03E4);
    check("R7 expiry wins", {22'd0, rd_data[9:0]}, 32'h084);
    check("R7 irq held", {27'd0, irq}, 32'h4);

    // R1/R5: sweep every enable pattern against every flag pattern
    for (int e = 0; e < 32; e++) begin
      for (int s = 0; s < 32; s++) begin
        step('0, 1'b1, 32'h0000_03E0);
        step(s[NCH-1:0], 1'b0, '0);
        step('0, 1'b1, {22'd0, 5'd0, e[NCH-1:0]});
        check("R1 layout", {22'd0, rd_data[9:0]}, {22'd0, s[4:0], e[4:0]});
      end
    end

    // Pseudo-random mixed traffic
    for (int k = 0; k < 3000; k++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      step(lfsr[4:0] & lfsr[9:5], lfsr[10], {lfsr[31:11], lfsr[10:0]});
    end

    // R6: reset mid-run
    step(5'b11111, 1'b1, 32'h1F);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    en_m = '0; st_m = '0;
    check("R6 reset clears word", rd_data, 32'd0);
    check("R6 reset clears irq", {27'd0, irq}, 32'd0);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule